// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Extended Lines

This block gathers interrupt requests for a small multiprocessor and presents each CPU with a 4-bit level request. There are fifteen regular sources, numbered 1 to 15, and sixteen extended sources, numbered 16 to 31. A source's rising edge marks it pending. Software can also raise a source by writing the force register and can drop it by writing the clear register. Every CPU has its own mask, so each CPU sees only the sources it has enabled.

The extended sources do not get levels of their own. When any of them is pending and enabled for a CPU, they request one shared regular level, set by the parameter `EXT_LEVEL`. A CPU acknowledges the level it is serving. That clears the matching regular pending bit. If the level is the shared extended level, the acknowledge also clears the highest-numbered extended source that CPU has pending and enabled. The number of that source is latched into the CPU's ID register, so software can tell which extended line it is serving.

Register accesses use a plain single-cycle bus. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The bus has no back-pressure, because every access completes in one cycle.

Top module: `mpx_irq_ctrl`

## Requirements
- R1: After reset, the pending register, every mask register and every ID register read 0, and every `cpu_lvl` field is 0.
- R2: A rising edge on `irq_in[n]`, for n from 1 to 31, sets pending bit n at the next clock edge. An input held high does not set the bit again after it has been cleared.
- R3: Writing to offset 0x04 (force) sets each pending bit n for which the write data has a 1, for n from 1 to 31. Bit 0 is ignored and always reads 0. The pending register is read at offset 0x00.
- R4: Writing to offset 0x08 (clear) clears each pending bit for which the write data has a 1. A clear, whether from this register or from an acknowledge, wins over a rising edge or a force that arrives in the same cycle for the same bit.
- R5: The mask for CPU c is at offset 0x40+4c, and it is read/write. The level field `cpu_lvl[4c+3:4c]` is the highest-numbered regular source that is pending and has its mask bit set to 1. It is 0 when there is none.
- R6: When any extended source (16 to 31) is pending and unmasked for a CPU, `EXT_LEVEL` takes part in that CPU's level selection as if it were a regular source.
- R7: An acknowledge pulse on `cpu_ack[c]` with a nonzero level L on `cpu_ack_lvl[4c+3:4c]` clears pending bit L at that clock edge.
- R8: An acknowledge at `EXT_LEVEL` also clears the highest-numbered extended source that is pending and unmasked for that CPU. It loads that source's number, with bit 4 set, into the CPU's ID register at offset 0x80+4c. If no such source exists, the ID register is loaded with 0. The ID registers of the other CPUs do not change.
- R9: The status register at offset 0x0C reads NCPU-1 in bits 31:28, a 1 in bit 27 (broadcast supported) and `EXT_LEVEL` in bits 3:0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Source request lines; bit 0 unused |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| cpu_ack | input | NCPU | Per-CPU acknowledge pulse |
| cpu_ack_lvl | input | 4*NCPU | Per-CPU level being acknowledged |
| cpu_lvl | output | 4*NCPU | Per-CPU interrupt level request |

## Verification
The hardest case to reach is a series of extended-level acknowledges that must step through the extended sources in descending order. Each CPU sees a different subset of those sources through its mask, and each step has to latch the right ID into only that CPU's register. The bench forces all sixteen extended bits at once. It gives one CPU a full mask and the other a sparse one, and acknowledges repeatedly at the shared level. It predicts each ID and the pending pattern left behind from a running model. A same-cycle clear and rising edge is produced by driving the line and the clear write on the same falling edge.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
  localparam int unsigned SRC_N = 32;
  localparam int unsigned LVL_W = 4;
  localparam int unsigned ID_W  = 5;

  typedef logic [SRC_N-1:0] src_vec_t;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam logic [7:0] OFS_PEND  = 8'h00;
  localparam logic [7:0] OFS_FORCE = 8'h04;
  localparam logic [7:0] OFS_CLEAR = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h0C;
  localparam logic [1:0] PAGE_GLOB = 2'b00;
  localparam logic [1:0] PAGE_MASK = 2'b01;
  localparam logic [1:0] PAGE_ID   = 2'b10;

  // highest set bit among positions 1..15, 0 when none
  function automatic lvl_t top_level(input logic [15:0] v);
    lvl_t r;
    r = '0;
    for (int i = 1; i < 16; i++)
      if (v[i]) r = lvl_t'(i);
    return r;
  endfunction

  // highest set bit index among 0..15
  function automatic logic [3:0] top_index(input logic [15:0] v);
    logic [3:0] r;
    r = '0;
    for (int i = 0; i < 16; i++)
      if (v[i]) r = 4'(i);
    return r;
  endfunction
endpackage

// File: rtl/mpx_pend_core.sv
module mpx_pend_core
  import mpx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t irq_in,
  input  src_vec_t force_vec,
  input  src_vec_t clr_vec,
  input  src_vec_t ack_clr,
  output src_vec_t pend_q
);
  src_vec_t prev_q;
  src_vec_t rise;
  src_vec_t pend_d;

  assign rise = irq_in & ~prev_q;

  always_comb begin
    pend_d    = (pend_q | rise | force_vec) & ~clr_vec & ~ack_clr;
    pend_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_in;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/mpx_cpu_port.sv
module mpx_cpu_port
  import mpx_pkg::*;
#(
  parameter int unsigned EXT_LEVEL = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  src_vec_t        pend,
  input  logic            mask_we,
  input  src_vec_t        mask_wdata,
  input  logic            ack,
  input  lvl_t            ack_lvl,
  output lvl_t            lvl,
  output src_vec_t        mask_q,
  output logic [ID_W-1:0] id_q,
  output src_vec_t        ack_clr
);
  localparam lvl_t EXT_L = lvl_t'(EXT_LEVEL);

  src_vec_t    eff;
  logic        ext_any;
  logic [3:0]  ext_idx;
  logic [15:0] reg_req;
  logic        ack_ext;

  assign eff     = pend & mask_q;
  assign ext_any = |eff[31:16];
  assign ext_idx = top_index(eff[31:16]);
  assign reg_req = (eff[15:0] & 16'hFFFE) | (ext_any ? (16'd1 << EXT_LEVEL) : 16'd0);
  assign lvl     = top_level(reg_req);
  assign ack_ext = ack && (ack_lvl == EXT_L);

  always_comb begin
    ack_clr = '0;
    if (ack && ack_lvl != '0) ack_clr[ack_lvl] = 1'b1;
    if (ack_ext && ext_any) ack_clr[5'd16 + {1'b0, ext_idx}] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      id_q   <= '0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (ack_ext) id_q <= ext_any ? {1'b1, ext_idx} : '0;
    end
  end
endmodule

// File: rtl/mpx_regbus.sv
module mpx_regbus
  import mpx_pkg::*;
#(
  parameter int unsigned NCPU      = 2,
  parameter int unsigned EXT_LEVEL = 10
) (
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  src_vec_t             pend,
  input  logic [NCPU*32-1:0]   masks,
  input  logic [NCPU*ID_W-1:0] ids,
  output src_vec_t             force_vec,
  output src_vec_t             clr_vec,
  output logic [NCPU-1:0]      mask_we
);
  localparam logic [31:0] STATUS_WORD =
    {4'(NCPU - 1), 1'b1, 23'd0, 4'(EXT_LEVEL)};

  logic [1:0] page;
  logic [3:0] idx;
  logic       idx_ok;

  assign page   = bus_addr[7:6];
  assign idx    = bus_addr[5:2];
  assign idx_ok = (int'(idx) < NCPU) && (bus_addr[1:0] == 2'b00);

  assign force_vec = (bus_wr && bus_addr == OFS_FORCE) ? bus_wdata : '0;
  assign clr_vec   = (bus_wr && bus_addr == OFS_CLEAR) ? bus_wdata : '0;

  for (genvar c = 0; c < NCPU; c++) begin : g_we
    assign mask_we[c] = bus_wr && page == PAGE_MASK && idx_ok && int'(idx) == c;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (page)
      PAGE_GLOB: begin
        if (bus_addr == OFS_PEND) bus_rdata = pend;
        else if (bus_addr == OFS_STAT) bus_rdata = STATUS_WORD;
      end
      PAGE_MASK: if (idx_ok) bus_rdata = masks[int'(idx)*32 +: 32];
      PAGE_ID:   if (idx_ok) bus_rdata = 32'(ids[int'(idx)*ID_W +: ID_W]);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mpx_irq_ctrl.sv
module mpx_irq_ctrl
  import mpx_pkg::*;
#(
  parameter int unsigned NCPU      = 2,
  parameter int unsigned EXT_LEVEL = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           irq_in,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NCPU-1:0]       cpu_ack,
  input  logic [NCPU*4-1:0]     cpu_ack_lvl,
  output logic [NCPU*4-1:0]     cpu_lvl
);
  src_vec_t             pend_q;
  src_vec_t             force_vec;
  src_vec_t             clr_vec;
  src_vec_t             ack_any;
  logic [NCPU-1:0]      mask_we;
  logic [NCPU*32-1:0]   mask_flat;
  logic [NCPU*ID_W-1:0] id_flat;
  src_vec_t             ack_clr [NCPU];

  mpx_pend_core u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .force_vec (force_vec),
    .clr_vec   (clr_vec),
    .ack_clr   (ack_any),
    .pend_q    (pend_q)
  );

  mpx_regbus #(.NCPU(NCPU), .EXT_LEVEL(EXT_LEVEL)) u_bus (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pend      (pend_q),
    .masks     (mask_flat),
    .ids       (id_flat),
    .force_vec (force_vec),
    .clr_vec   (clr_vec),
    .mask_we   (mask_we)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    mpx_cpu_port #(.EXT_LEVEL(EXT_LEVEL)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend       (pend_q),
      .mask_we    (mask_we[c]),
      .mask_wdata (bus_wdata),
      .ack        (cpu_ack[c]),
      .ack_lvl    (cpu_ack_lvl[c*4 +: 4]),
      .lvl        (cpu_lvl[c*4 +: 4]),
      .mask_q     (mask_flat[c*32 +: 32]),
      .id_q       (id_flat[c*ID_W +: ID_W]),
      .ack_clr    (ack_clr[c])
    );
  end

  always_comb begin
    ack_any = '0;
    for (int c = 0; c < NCPU; c++) ack_any |= ack_clr[c];
  end
endmodule

// File: rtl/mpx_irq_ctrl_chk.sv
module mpx_irq_ctrl_chk
  import mpx_pkg::*;
#(
  parameter int unsigned NCPU      = 2,
  parameter int unsigned EXT_LEVEL = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [7:0]            bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [NCPU-1:0]       cpu_ack,
  input logic [NCPU*4-1:0]     cpu_ack_lvl,
  input logic [NCPU*4-1:0]     cpu_lvl,
  input logic [31:0]           pend_q,
  input logic [NCPU*ID_W-1:0]  id_flat
);
  localparam logic [3:0] EXT_L = 4'(EXT_LEVEL);

  AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_FORCE && cpu_ack == '0) |=>
      ((pend_q & $past(bus_wdata) & 32'hFFFF_FFFE) == ($past(bus_wdata) & 32'hFFFF_FFFE))); // R3

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CLEAR) |=> ((pend_q & $past(bus_wdata)) == 32'd0)); // R4

  AST_STATUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_STAT) |-> (bus_rdata[31:27] == {4'(NCPU - 1), 1'b1})); // R9

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu_chk
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == 32'd0) |-> (cpu_lvl[c*4 +: 4] == 4'd0)); // R5

    AST_LVL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_lvl[c*4 +: 4] != 4'd0 && cpu_lvl[c*4 +: 4] != EXT_L) |->
        pend_q[cpu_lvl[c*4 +: 4]]); // R5

    AST_EXT_LVL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_lvl[c*4 +: 4] == EXT_L) |-> (pend_q[EXT_LEVEL] || (pend_q[31:16] != 16'd0))); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack[c] && cpu_ack_lvl[c*4 +: 4] != 4'd0) |=>
        !pend_q[$past(cpu_ack_lvl[c*4 +: 4])]); // R7

    AST_ID_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack[c] && cpu_ack_lvl[c*4 +: 4] == EXT_L) |=>
        (id_flat[c*ID_W +: ID_W] == 5'd0) ||
        (id_flat[c*ID_W + 4] && !pend_q[id_flat[c*ID_W +: ID_W]])); // R8
  end
endmodule

bind mpx_irq_ctrl mpx_irq_ctrl_chk #(.NCPU(NCPU), .EXT_LEVEL(EXT_LEVEL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .cpu_ack     (cpu_ack),
  .cpu_ack_lvl (cpu_ack_lvl),
  .cpu_lvl     (cpu_lvl),
  .pend_q      (pend_q),
  .id_flat     (id_flat)
);

// File: tb/mpx_irq_ctrl_bench.sv
`timescale 1ns/100ps
module mpx_irq_ctrl_bench;
  localparam int NCPU = 2;
  localparam int EXTL = 10;
  localparam logic [31:0] MASK1 = 32'h5555_A5A6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       irq_in = '0;
  logic              bus_wr = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCPU-1:0]   cpu_ack = '0;
  logic [NCPU*4-1:0] cpu_ack_lvl = '0;
  logic [NCPU*4-1:0] cpu_lvl;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mpx_irq_ctrl #(.NCPU(NCPU), .EXT_LEVEL(EXTL)) u_mpx_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_ack(cpu_ack), .cpu_ack_lvl(cpu_ack_lvl), .cpu_lvl(cpu_lvl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ack(input int c, input logic [3:0] l);
    @(negedge clk);
    cpu_ack[c] = 1'b1; cpu_ack_lvl[c*4 +: 4] = l;
    @(negedge clk);
    cpu_ack = '0; cpu_ack_lvl = '0;
  endtask

  function automatic logic [31:0] exp_lvl(input logic [31:0] p, input logic [31:0] m);
    logic [31:0] e;
    int r;
    e = p & m & 32'hFFFF_FFFE;
    r = 0;
    for (int i = 1; i < 16; i++) if (e[i]) r = i;
    if (e[31:16] != 0 && EXTL > r) r = EXTL;
    return 32'(r);
  endfunction

  function automatic int hi_ext(input logic [31:0] e);
    int r;
    r = 0;
    for (int i = 16; i < 32; i++) if (e[i]) r = i;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] p;
    logic [31:0] ep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); check("R1 pending", d, 32'd0);
    rd(8'h40, d); check("R1 mask0", d, 32'd0);
    rd(8'h44, d); check("R1 mask1", d, 32'd0);
    rd(8'h80, d); check("R1 id0", d, 32'd0);
    rd(8'h84, d); check("R1 id1", d, 32'd0);
    check("R1 levels", 32'(cpu_lvl), 32'd0);

    // R9 status
    rd(8'h0C, d); check("R9 status", d, {4'(NCPU - 1), 1'b1, 23'd0, 4'(EXTL)});

    // R3/R4 force and clear sweep
    for (int n = 0; n < 32; n++) begin
      wr(8'h04, 32'd1 << n);
      rd(8'h00, d); check("R3 force", d, (32'd1 << n) & 32'hFFFF_FFFE);
      rd(8'h04, d); check("R3 force reads zero", d, 32'd0);
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h00, d); check("R4 clear", d, 32'd0);
    end

    // R2 edge capture and held level
    for (int n = 1; n < 32; n++) begin
      @(negedge clk); irq_in[n] = 1'b1;
      @(negedge clk);
      rd(8'h00, d); check("R2 edge sets", d, 32'd1 << n);
      wr(8'h08, 32'd1 << n);
      @(negedge clk);
      rd(8'h00, d); check("R2 held no reset", d, 32'd0);
      irq_in[n] = 1'b0;
      @(negedge clk);
    end

    // R4 clear beats a same-cycle edge
    for (int n = 1; n < 32; n++) begin
      @(negedge clk);
      irq_in[n] = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'd1 << n;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(8'h00, d); check("R4 clear beats edge", d, 32'd0);
      irq_in[n] = 1'b0;
      @(negedge clk);
    end

    // R5 masks
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, MASK1);
    rd(8'h40, d); check("R5 mask0 rd", d, 32'hFFFF_FFFF);
    rd(8'h44, d); check("R5 mask1 rd", d, MASK1);

    // R5/R6 pairwise level sweep
    for (int i = 1; i < 32; i++) begin
      for (int j = i; j < 32; j++) begin
        p = (32'd1 << i) | (32'd1 << j);
        wr(8'h04, p);
        check("R5 R6 lvl cpu0", 32'(cpu_lvl[3:0]), exp_lvl(p, 32'hFFFF_FFFF));
        check("R5 R6 lvl cpu1", 32'(cpu_lvl[7:4]), exp_lvl(p, MASK1));
        wr(8'h08, 32'hFFFF_FFFF);
      end
    end

    // R7 regular acknowledge
    wr(8'h04, 32'h0000_0088);
    check("R7 lvl before", 32'(cpu_lvl[3:0]), 32'd7);
    ack(0, 4'd7);
    rd(8'h00, d); check("R7 ack clears", d, 32'h0000_0008);
    check("R7 lvl after", 32'(cpu_lvl[3:0]), 32'd3);
    ack(0, 4'd3);
    rd(8'h00, d); check("R7 ack clears last", d, 32'd0);

    // R8 extended acknowledge, full mask on cpu0
    wr(8'h04, 32'hFFFF_0000);
    ep = 32'hFFFF_0000;
    for (int k = 31; k >= 16; k--) begin
      check("R6 ext lvl", 32'(cpu_lvl[3:0]), 32'(EXTL));
      ack(0, 4'(EXTL));
      ep &= ~(32'd1 << k);
      rd(8'h80, d); check("R8 id0", d, 32'(k));
      rd(8'h00, d); check("R8 ext cleared", d, ep);
      rd(8'h84, d); check("R8 id1 untouched", d, 32'd0);
    end
    ack(0, 4'(EXTL));
    rd(8'h80, d); check("R8 id0 none", d, 32'd0);

    // R8 extended acknowledge, sparse mask on cpu1
    wr(8'h04, 32'hFFFF_0000);
    ep = 32'hFFFF_0000;
    for (int s = 0; s < 8; s++) begin
      int k;
      k = hi_ext(ep & MASK1);
      ack(1, 4'(EXTL));
      ep &= ~(32'd1 << k);
      rd(8'h84, d); check("R8 id1", d, 32'(k));
      rd(8'h00, d); check("R8 ext cleared cpu1", d, ep);
      rd(8'h80, d); check("R8 id0 untouched", d, 32'd0);
    end
    check("R6 cpu1 none left", 32'(cpu_lvl[7:4]), 32'd0);
    check("R6 cpu0 still ext", 32'(cpu_lvl[3:0]), 32'(EXTL));
    wr(8'h08, 32'hFFFF_FFFF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule